// File: doc/BRIEF.md
# Translation Address Size Checker

This block sits next to an address translation unit and judges each translation request against the configured address sizes. For every request it receives the implemented physical address size code, the per-stage output size codes, the input size fields of both stages, the two stage enables, a fault-handling mode, the input address, and the addresses produced while walking each stage: the table base, one table-entry output address with its lookup level, and the final output address with its level. Range selection (lower or upper half of a split first-stage space) arrives as a ready-made input.

One cycle after a request strobe the block reports whether a fault applies, its kind (address size or translation), the stage that takes it and the lookup level. Out-of-range size fields are either clamped or turned into a level 0 translation fault, as the mode input selects. When the first stage is off, the input address is checked against the physical size and passed straight to the second stage as its input. When the second stage is off, its inputs have no effect.

Top module: `xlat_size_guard`

## Requirements
- R1: Output size codes map as 0→32, 1→36, 2→40, 3→42, 4→44, 5→48 bits. A physical size code of 6 or 7 means 48 bits. A stage output code of 6 or 7, or a code whose width exceeds the physical size, uses the physical size.
- R2: With the first stage enabled, any set bit at or above the stage's effective output size in the table base, the table-entry address or the final output gives an address size fault (kind 1) at stage 0. The level is 0 for the base, `s1EntryLevel` for the entry and `s1OutLevel` for the output.
- R3: With the first stage disabled, an input address with a set bit at or above the physical size gives a stage 0, level 0 address size fault. The first-stage base and entry addresses are then ignored.
- R4: With the first stage enabled, the region width is 64 minus the selected input size field (`s1InSizeHi` when `s1UpperRange` is 1, else `s1InSizeLo`). In the lower range every input bit at or above the region width must be 0, and in the upper range it must be 1. Otherwise a translation fault (kind 2) is raised at stage 0, level 0.
- R5: The first-stage input size field has a legal range of 16 to 39. With `faultMode` 0 an out-of-range value is clamped to the nearest limit. With `faultMode` 1 it gives a stage 0, level 0 translation fault.
- R6: The second-stage input size field has a legal range of (64 minus the physical size) to 39. It is clamped or faulted in the same way as R5, at stage 1, level 0.
- R7: With the second stage enabled, its input address must have no set bit at or above its region width. This input is the first-stage output, or the input address when the first stage is off. A violation gives a translation fault at stage 1, level 0.
- R8: With the second stage enabled, its table base, entry address and final output are checked against its effective output size in the same way as R2. Any violation gives an address size fault at stage 1, with level 0, `s2EntryLevel` or `s2OutLevel` respectively.
- R9: Only the highest-priority violation is reported. The order is: first-stage field or input translation fault, first-stage base, first-stage entry, first-stage output, second-stage field or input translation fault, second-stage base, second-stage entry, second-stage output.
- R10: The result appears with `rspValid` high in the cycle after `reqValid`. `faultKind` is 0 for none, 1 for address size and 2 for translation, and `faultStage` is 0 for the first stage and 1 for the second. With no fault, stage and level read 0. `rspValid` is low in cycles without a request, while the fault fields hold their last value. Reset clears all outputs.
- R11: With the second stage disabled, no second-stage fault is ever reported, whatever its fields and addresses hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| paSizeCode | input | 3 | Implemented physical size code |
| faultMode | input | 1 | 0 clamps out-of-range size fields, 1 faults on them |
| s1Enable | input | 1 | First stage enabled |
| s2Enable | input | 1 | Second stage enabled |
| s1OutSizeCode | input | 3 | First-stage output size code |
| s2OutSizeCode | input | 3 | Second-stage output size code |
| s1InSizeLo | input | 6 | First-stage input size field, lower range |
| s1InSizeHi | input | 6 | First-stage input size field, upper range |
| s1UpperRange | input | 1 | Request uses the upper range |
| s2InSize | input | 6 | Second-stage input size field |
| inAddr | input | 64 | Input address of the request |
| s1TableBase | input | 64 | First-stage table base address |
| s1EntryAddr | input | 64 | First-stage table-entry output address |
| s1EntryLevel | input | 2 | Level that produced `s1EntryAddr` |
| s1OutAddr | input | 64 | First-stage final output address |
| s1OutLevel | input | 2 | Level that produced `s1OutAddr` |
| s2TableBase | input | 64 | Second-stage table base address |
| s2EntryAddr | input | 64 | Second-stage table-entry output address |
| s2EntryLevel | input | 2 | Level that produced `s2EntryAddr` |
| s2OutAddr | input | 64 | Second-stage final output address |
| s2OutLevel | input | 2 | Level that produced `s2OutAddr` |
| rspValid | output | 1 | Result valid |
| faultKind | output | 2 | 0 none, 1 address size, 2 translation |
| faultStage | output | 1 | 0 first stage, 1 second stage |
| faultLevel | output | 2 | Lookup level of the fault |

## Verification
The hardest situations to reach are those where several violations are present at once and only the priority order decides the outcome. Examples are a first-stage input fault together with an oversized table base, or a first-stage entry fault together with a second-stage input overflow. A close second is the clamp boundary, where a field one step outside its limit must behave exactly like the limit. The vector table builds each of these cases directly. It plants a single high bit at a chosen position in a chosen address and sets the size fields just past their limits, in both modes. It also lowers the physical size, which raises the second stage's minimum field value.

// File: rtl/xsg_pkg.sv
package xsg_pkg;

  typedef enum logic [1:0] {
    FLT_NONE        = 2'd0,
    FLT_ADDR_SIZE   = 2'd1,
    FLT_TRANSLATION = 2'd2
  } faultKind_e;

  // Violation strobes from the datapath to the priority control
  typedef struct packed {
    logic s1FieldBad;
    logic s1InBad;
    logic s1PaBad;
    logic s1BaseBad;
    logic s1DescBad;
    logic s1OutBad;
    logic s2FieldBad;
    logic s2IpaBad;
    logic s2BaseBad;
    logic s2DescBad;
    logic s2OutBad;
  } sizeStrobes_t;

  // Width in bits for a 3-bit size code; 0 marks a reserved code
  function automatic logic [6:0] codeToBits(input logic [2:0] code);
    case (code)
      3'd0:    return 7'd32;
      3'd1:    return 7'd36;
      3'd2:    return 7'd40;
      3'd3:    return 7'd42;
      3'd4:    return 7'd44;
      3'd5:    return 7'd48;
      default: return 7'd0;
    endcase
  endfunction

endpackage

// File: rtl/xsg_size_field.sv
module xsg_size_field #(
  parameter int TSZ_W   = 6,
  parameter int WID_W   = 7,
  parameter int ADDR_W  = 64,
  parameter int MAX_TSZ = 39
) (
  input  logic [TSZ_W-1:0] rawSize,
  input  logic [WID_W-1:0] minSize,
  input  logic             faultMode,
  output logic [WID_W-1:0] regionBits,
  output logic             fieldBad
);
  localparam logic [WID_W-1:0] MaxSize  = WID_W'(MAX_TSZ);
  localparam logic [WID_W-1:0] FullBits = WID_W'(ADDR_W);

  logic [WID_W-1:0] extSize;
  logic [WID_W-1:0] effSize;
  logic             tooBig;
  logic             tooSmall;

  always_comb begin
    extSize  = WID_W'(rawSize);
    tooBig   = extSize > MaxSize;
    tooSmall = extSize < minSize;
    if (tooBig)        effSize = MaxSize;
    else if (tooSmall) effSize = minSize;
    else               effSize = extSize;
    regionBits = FullBits - effSize;
    fieldBad   = faultMode & (tooBig | tooSmall);
  end

endmodule

// File: rtl/xsg_datapath.sv
module xsg_datapath import xsg_pkg::*; #(
  parameter int ADDR_W      = 64,
  parameter int TSZ_W       = 6,
  parameter int MAX_OA_BITS = 48,
  parameter int MAX_TSZ     = 39,
  parameter int MIN_TSZ_S1  = 16
) (
  input  logic [2:0]        paSizeCode,
  input  logic              faultMode,
  input  logic              s1Enable,
  input  logic [2:0]        s1OutSizeCode,
  input  logic [2:0]        s2OutSizeCode,
  input  logic [TSZ_W-1:0]  s1InSizeLo,
  input  logic [TSZ_W-1:0]  s1InSizeHi,
  input  logic              s1UpperRange,
  input  logic [TSZ_W-1:0]  s2InSize,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [ADDR_W-1:0] s1TableBase,
  input  logic [ADDR_W-1:0] s1EntryAddr,
  input  logic [ADDR_W-1:0] s1OutAddr,
  input  logic [ADDR_W-1:0] s2TableBase,
  input  logic [ADDR_W-1:0] s2EntryAddr,
  input  logic [ADDR_W-1:0] s2OutAddr,
  output sizeStrobes_t      strobes
);
  localparam int WID_W = $clog2(ADDR_W + 1);
  localparam logic [WID_W-1:0] FullBits = WID_W'(ADDR_W);
  localparam logic [WID_W-1:0] MaxOa    = WID_W'(MAX_OA_BITS);
  localparam logic [WID_W-1:0] MinS1    = WID_W'(MIN_TSZ_S1);

  // true when any bit at or above position w is set
  function automatic logic exceeds(input logic [ADDR_W-1:0] a,
                                   input logic [WID_W-1:0]  w);
    return (a >> w) != '0;
  endfunction

  function automatic logic [WID_W-1:0] stageOa(input logic [2:0]       code,
                                               input logic [WID_W-1:0] pa);
    logic [WID_W-1:0] raw;
    raw = WID_W'(codeToBits(code));
    return (raw == '0 || raw > pa) ? pa : raw;
  endfunction

  logic [WID_W-1:0]  paRaw;
  logic [WID_W-1:0]  effPa;
  logic [WID_W-1:0]  effOs1;
  logic [WID_W-1:0]  effOs2;
  logic [WID_W-1:0]  s2MinSize;
  logic [TSZ_W-1:0]  s1RawSize;
  logic [WID_W-1:0]  s1Region;
  logic [WID_W-1:0]  s2Region;
  logic              s1FieldBadW;
  logic              s2FieldBadW;
  logic [ADDR_W-1:0] ipa;

  always_comb begin
    paRaw     = WID_W'(codeToBits(paSizeCode));
    effPa     = (paRaw == '0) ? MaxOa : paRaw;
    effOs1    = stageOa(s1OutSizeCode, effPa);
    effOs2    = stageOa(s2OutSizeCode, effPa);
    s2MinSize = FullBits - effPa;
    s1RawSize = s1UpperRange ? s1InSizeHi : s1InSizeLo;
    ipa       = s1Enable ? s1OutAddr : inAddr;
  end

  xsg_size_field #(
    .TSZ_W(TSZ_W), .WID_W(WID_W), .ADDR_W(ADDR_W), .MAX_TSZ(MAX_TSZ)
  ) u_s1Field (
    .rawSize(s1RawSize), .minSize(MinS1), .faultMode(faultMode),
    .regionBits(s1Region), .fieldBad(s1FieldBadW)
  );

  xsg_size_field #(
    .TSZ_W(TSZ_W), .WID_W(WID_W), .ADDR_W(ADDR_W), .MAX_TSZ(MAX_TSZ)
  ) u_s2Field (
    .rawSize(s2InSize), .minSize(s2MinSize), .faultMode(faultMode),
    .regionBits(s2Region), .fieldBad(s2FieldBadW)
  );

  always_comb begin
    strobes.s1FieldBad = s1FieldBadW;
    strobes.s1InBad    = s1UpperRange ? exceeds(~inAddr, s1Region)
                                      : exceeds(inAddr, s1Region);
    strobes.s1PaBad    = exceeds(inAddr, effPa);
    strobes.s1BaseBad  = exceeds(s1TableBase, effOs1);
    strobes.s1DescBad  = exceeds(s1EntryAddr, effOs1);
    strobes.s1OutBad   = exceeds(s1OutAddr, effOs1);
    strobes.s2FieldBad = s2FieldBadW;
    strobes.s2IpaBad   = exceeds(ipa, s2Region);
    strobes.s2BaseBad  = exceeds(s2TableBase, effOs2);
    strobes.s2DescBad  = exceeds(s2EntryAddr, effOs2);
    strobes.s2OutBad   = exceeds(s2OutAddr, effOs2);
  end

endmodule

// File: rtl/xsg_control.sv
module xsg_control import xsg_pkg::*; #(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             s1Enable,
  input  logic             s2Enable,
  input  logic [LVL_W-1:0] s1EntryLevel,
  input  logic [LVL_W-1:0] s1OutLevel,
  input  logic [LVL_W-1:0] s2EntryLevel,
  input  logic [LVL_W-1:0] s2OutLevel,
  input  sizeStrobes_t     strobes,
  output logic             rspValid,
  output logic [1:0]       faultKind,
  output logic             faultStage,
  output logic [LVL_W-1:0] faultLevel
);
  faultKind_e       nextKind;
  logic             nextStage;
  logic [LVL_W-1:0] nextLevel;
  logic             s1Hit;

  always_comb begin
    nextKind  = FLT_NONE;
    nextStage = 1'b0;
    nextLevel = '0;
    s1Hit     = 1'b1;
    if (s1Enable) begin
      if (strobes.s1FieldBad || strobes.s1InBad) begin
        nextKind = FLT_TRANSLATION;
      end else if (strobes.s1BaseBad) begin
        nextKind = FLT_ADDR_SIZE;
      end else if (strobes.s1DescBad) begin
        nextKind  = FLT_ADDR_SIZE;
        nextLevel = s1EntryLevel;
      end else if (strobes.s1OutBad) begin
        nextKind  = FLT_ADDR_SIZE;
        nextLevel = s1OutLevel;
      end else begin
        s1Hit = 1'b0;
      end
    end else if (strobes.s1PaBad) begin
      nextKind = FLT_ADDR_SIZE;
    end else begin
      s1Hit = 1'b0;
    end

    if (!s1Hit && s2Enable) begin
      nextStage = 1'b1;
      if (strobes.s2FieldBad || strobes.s2IpaBad) begin
        nextKind = FLT_TRANSLATION;
      end else if (strobes.s2BaseBad) begin
        nextKind = FLT_ADDR_SIZE;
      end else if (strobes.s2DescBad) begin
        nextKind  = FLT_ADDR_SIZE;
        nextLevel = s2EntryLevel;
      end else if (strobes.s2OutBad) begin
        nextKind  = FLT_ADDR_SIZE;
        nextLevel = s2OutLevel;
      end else begin
        nextStage = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      faultKind  <= 2'd0;
      faultStage <= 1'b0;
      faultLevel <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        faultKind  <= nextKind;
        faultStage <= nextStage;
        faultLevel <= nextLevel;
      end
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R10
  AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R10
  AST_CLEAN_RESULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && faultKind == 2'd0) |-> (!faultStage && faultLevel == '0)); // R10
  AST_S2_OFF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !s2Enable) |=> !faultStage); // R11
  AST_S1_OFF_NO_XLAT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !s1Enable) |=> !(faultKind == 2'd2 && !faultStage)); // R3
  AST_S1_BASE_LEVEL0: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && s1Enable && strobes.s1BaseBad && !strobes.s1FieldBad && !strobes.s1InBad)
    |=> (faultKind == 2'd1 && !faultStage && faultLevel == '0)); // R2
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> faultKind != 2'd3); // R10

endmodule

// File: rtl/xlat_size_guard.sv
module xlat_size_guard import xsg_pkg::*; #(
  parameter int ADDR_W      = 64,
  parameter int TSZ_W       = 6,
  parameter int LVL_W       = 2,
  parameter int MAX_OA_BITS = 48,
  parameter int MAX_TSZ     = 39,
  parameter int MIN_TSZ_S1  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        paSizeCode,
  input  logic              faultMode,
  input  logic              s1Enable,
  input  logic              s2Enable,
  input  logic [2:0]        s1OutSizeCode,
  input  logic [2:0]        s2OutSizeCode,
  input  logic [TSZ_W-1:0]  s1InSizeLo,
  input  logic [TSZ_W-1:0]  s1InSizeHi,
  input  logic              s1UpperRange,
  input  logic [TSZ_W-1:0]  s2InSize,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [ADDR_W-1:0] s1TableBase,
  input  logic [ADDR_W-1:0] s1EntryAddr,
  input  logic [LVL_W-1:0]  s1EntryLevel,
  input  logic [ADDR_W-1:0] s1OutAddr,
  input  logic [LVL_W-1:0]  s1OutLevel,
  input  logic [ADDR_W-1:0] s2TableBase,
  input  logic [ADDR_W-1:0] s2EntryAddr,
  input  logic [LVL_W-1:0]  s2EntryLevel,
  input  logic [ADDR_W-1:0] s2OutAddr,
  input  logic [LVL_W-1:0]  s2OutLevel,
  output logic              rspValid,
  output logic [1:0]        faultKind,
  output logic              faultStage,
  output logic [LVL_W-1:0]  faultLevel
);
  sizeStrobes_t strobes;

  xsg_datapath #(
    .ADDR_W(ADDR_W), .TSZ_W(TSZ_W), .MAX_OA_BITS(MAX_OA_BITS),
    .MAX_TSZ(MAX_TSZ), .MIN_TSZ_S1(MIN_TSZ_S1)
  ) u_datapath (
    .paSizeCode(paSizeCode), .faultMode(faultMode), .s1Enable(s1Enable),
    .s1OutSizeCode(s1OutSizeCode), .s2OutSizeCode(s2OutSizeCode),
    .s1InSizeLo(s1InSizeLo), .s1InSizeHi(s1InSizeHi),
    .s1UpperRange(s1UpperRange), .s2InSize(s2InSize), .inAddr(inAddr),
    .s1TableBase(s1TableBase), .s1EntryAddr(s1EntryAddr),
    .s1OutAddr(s1OutAddr), .s2TableBase(s2TableBase),
    .s2EntryAddr(s2EntryAddr), .s2OutAddr(s2OutAddr), .strobes(strobes)
  );

  xsg_control #(.LVL_W(LVL_W)) u_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .s1Enable(s1Enable), .s2Enable(s2Enable),
    .s1EntryLevel(s1EntryLevel), .s1OutLevel(s1OutLevel),
    .s2EntryLevel(s2EntryLevel), .s2OutLevel(s2OutLevel),
    .strobes(strobes), .rspValid(rspValid), .faultKind(faultKind),
    .faultStage(faultStage), .faultLevel(faultLevel)
  );

endmodule

// File: tb/xlat_size_guard_test.sv
`timescale 1ns/1ps
module xlat_size_guard_test;

  typedef struct packed {
    logic [2:0]  pa;
    logic        s1En;
    logic        s2En;
    logic [2:0]  os1;
    logic [2:0]  os2;
    logic [5:0]  t1;
    logic        hi;
    logic [5:0]  t2;
    logic        mode;
    logic [63:0] inA;
    logic [63:0] s1O;
    logic [63:0] s2O;
    logic [2:0]  badSel;   // 1 s1 base, 2 s1 entry, 3 s2 base, 4 s2 entry
    logic [5:0]  badBit;
    logic [1:0]  eKind;
    logic        eStg;
    logic [1:0]  eLvl;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    // R10 clean request
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd16,1'b0,6'd16,1'b0,64'h1234_5678,64'h1000,64'h2000,3'd0,6'd0,2'd0,1'b0,2'd0,4'd10},
    // R1 stage code 40 bits, output at bit 40
    '{3'd5,1'b1,1'b1,3'd2,3'd5,6'd16,1'b0,6'd16,1'b0,64'h1000,64'h100_0000_0000,64'h2000,3'd0,6'd0,2'd1,1'b0,2'd3,4'd1},
    // R1 physical 36 caps stage code 48
    '{3'd1,1'b1,1'b1,3'd5,3'd5,6'd16,1'b0,6'd16,1'b0,64'h1000,64'h10_0000_0000,64'h2000,3'd0,6'd0,2'd1,1'b0,2'd3,4'd1},
    // R1 reserved stage code 7 uses physical 40
    '{3'd2,1'b1,1'b1,3'd7,3'd5,6'd16,1'b0,6'd24,1'b0,64'h1000,64'h80_0000_0000,64'h3000,3'd0,6'd0,2'd0,1'b0,2'd0,4'd1},
    // R1 reserved physical code 6 means 48
    '{3'd6,1'b1,1'b1,3'd5,3'd5,6'd16,1'b0,6'd16,1'b0,64'h1000,64'h1_0000_0000_0000,64'h2000,3'd0,6'd0,2'd1,1'b0,2'd3,4'd1},
    // R2 table base above 44 bits -> level 0
    '{3'd5,1'b1,1'b1,3'd4,3'd5,6'd16,1'b0,6'd16,1'b0,64'h1000,64'h1000,64'h2000,3'd1,6'd44,2'd1,1'b0,2'd0,4'd2},
    // R2 table entry above 44 bits -> entry level 2
    '{3'd5,1'b1,1'b1,3'd4,3'd5,6'd16,1'b0,6'd16,1'b0,64'h1000,64'h1000,64'h2000,3'd2,6'd44,2'd1,1'b0,2'd2,4'd2},
    // R3 stage 1 off, input at bit 40 with physical 40
    '{3'd2,1'b0,1'b0,3'd5,3'd5,6'd16,1'b0,6'd16,1'b0,64'h100_0000_0000,64'h1000,64'h2000,3'd0,6'd0,2'd1,1'b0,2'd0,4'd3},
    // R3 stage 1 off, top legal input, bad base ignored
    '{3'd2,1'b0,1'b0,3'd5,3'd5,6'd16,1'b0,6'd16,1'b0,64'hFF_FFFF_FFFF,64'h1000,64'h2000,3'd1,6'd50,2'd0,1'b0,2'd0,4'd3},
    // R4 lower range, region 39, input bit 39
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd25,1'b0,6'd16,1'b0,64'h80_0000_0000,64'h1000,64'h2000,3'd0,6'd0,2'd2,1'b0,2'd0,4'd4},
    // R4 upper range, all high bits ones
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd25,1'b1,6'd16,1'b0,64'hFFFF_FF80_0000_0000,64'h1000,64'h2000,3'd0,6'd0,2'd0,1'b0,2'd0,4'd4},
    // R4 upper range, bit 39 clear
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd25,1'b1,6'd16,1'b0,64'hFFFF_FF00_0000_0000,64'h1000,64'h2000,3'd0,6'd0,2'd2,1'b0,2'd0,4'd4},
    // R5 field 45 clamped to 39, input bit 25
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd45,1'b0,6'd16,1'b0,64'h200_0000,64'h1000,64'h2000,3'd0,6'd0,2'd2,1'b0,2'd0,4'd5},
    // R5 field 45 clamped to 39, top legal input
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd45,1'b0,6'd16,1'b0,64'h1FF_FFFF,64'h1000,64'h2000,3'd0,6'd0,2'd0,1'b0,2'd0,4'd5},
    // R5 field 45 in fault mode
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd45,1'b0,6'd16,1'b1,64'h10,64'h1000,64'h2000,3'd0,6'd0,2'd2,1'b0,2'd0,4'd5},
    // R5 field 10 clamped to 16, input bit 47
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd10,1'b0,6'd16,1'b0,64'h8000_0000_0000,64'h1000,64'h2000,3'd0,6'd0,2'd0,1'b0,2'd0,4'd5},
    // R5 field 10 in fault mode
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd10,1'b0,6'd16,1'b1,64'h10,64'h1000,64'h2000,3'd0,6'd0,2'd2,1'b0,2'd0,4'd5},
    // R6 stage 2 field 45 clamped, ipa bit 25
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd16,1'b0,6'd45,1'b0,64'h1000,64'h200_0000,64'h2000,3'd0,6'd0,2'd2,1'b1,2'd0,4'd6},
    // R6 stage 2 field 10 clamped to 16, ipa bit 47
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd16,1'b0,6'd10,1'b0,64'h1000,64'h8000_0000_0000,64'h2000,3'd0,6'd0,2'd0,1'b0,2'd0,4'd6},
    // R6 stage 2 field 10 in fault mode
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd16,1'b0,6'd10,1'b1,64'h1000,64'h1000,64'h2000,3'd0,6'd0,2'd2,1'b1,2'd0,4'd6},
    // R6 physical 40 raises minimum to 24, field 20 faults
    '{3'd2,1'b1,1'b1,3'd5,3'd5,6'd16,1'b0,6'd20,1'b1,64'h1000,64'h1000,64'h2000,3'd0,6'd0,2'd2,1'b1,2'd0,4'd6},
    // R7 stage 2 region 34, stage 1 output bit 34
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd16,1'b0,6'd30,1'b0,64'h1000,64'h4_0000_0000,64'h2000,3'd0,6'd0,2'd2,1'b1,2'd0,4'd7},
    // R7 stage 1 off, input used as ipa
    '{3'd5,1'b0,1'b1,3'd5,3'd5,6'd16,1'b0,6'd30,1'b0,64'h4_0000_0000,64'h1000,64'h2000,3'd0,6'd0,2'd2,1'b1,2'd0,4'd7},
    // R8 stage 2 base above 44
    '{3'd5,1'b1,1'b1,3'd5,3'd4,6'd16,1'b0,6'd16,1'b0,64'h1000,64'h1000,64'h2000,3'd3,6'd44,2'd1,1'b1,2'd0,4'd8},
    // R8 stage 2 entry above 44 -> level 1
    '{3'd5,1'b1,1'b1,3'd5,3'd4,6'd16,1'b0,6'd16,1'b0,64'h1000,64'h1000,64'h2000,3'd4,6'd44,2'd1,1'b1,2'd1,4'd8},
    // R8 stage 2 output above 44 -> level 3
    '{3'd5,1'b1,1'b1,3'd5,3'd4,6'd16,1'b0,6'd16,1'b0,64'h1000,64'h1000,64'h1000_0000_0000,3'd0,6'd0,2'd1,1'b1,2'd3,4'd8},
    // R11 stage 2 off, all its inputs bad
    '{3'd5,1'b1,1'b0,3'd5,3'd5,6'd16,1'b0,6'd45,1'b1,64'h1000,64'h1000,64'h1000_0000_0000_0000,3'd3,6'd60,2'd0,1'b0,2'd0,4'd11},
    // R11 stage 2 off, stage 1 output over physical 40
    '{3'd2,1'b1,1'b0,3'd5,3'd5,6'd16,1'b0,6'd16,1'b0,64'h1000,64'h100_0000_0000,64'h2000,3'd0,6'd0,2'd1,1'b0,2'd3,4'd11},
    // R9 input fault beats base fault
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd25,1'b0,6'd16,1'b0,64'h80_0000_0000,64'h1000,64'h2000,3'd1,6'd50,2'd2,1'b0,2'd0,4'd9},
    // R9 stage 1 entry beats stage 2 ipa
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd16,1'b0,6'd30,1'b0,64'h1000,64'h4_0000_0000,64'h2000,3'd2,6'd50,2'd1,1'b0,2'd2,4'd9},
    // R9 stage 2 field fault beats stage 2 base
    '{3'd5,1'b1,1'b1,3'd5,3'd5,6'd16,1'b0,6'd45,1'b1,64'h1000,64'h1000,64'h2000,3'd3,6'd50,2'd2,1'b1,2'd0,4'd9}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [2:0]  paSizeCode;
  logic        faultMode;
  logic        s1Enable;
  logic        s2Enable;
  logic [2:0]  s1OutSizeCode;
  logic [2:0]  s2OutSizeCode;
  logic [5:0]  s1InSizeLo;
  logic [5:0]  s1InSizeHi;
  logic        s1UpperRange;
  logic [5:0]  s2InSize;
  logic [63:0] inAddr;
  logic [63:0] s1TableBase;
  logic [63:0] s1EntryAddr;
  logic [1:0]  s1EntryLevel;
  logic [63:0] s1OutAddr;
  logic [1:0]  s1OutLevel;
  logic [63:0] s2TableBase;
  logic [63:0] s2EntryAddr;
  logic [1:0]  s2EntryLevel;
  logic [63:0] s2OutAddr;
  logic [1:0]  s2OutLevel;
  logic        rspValid;
  logic [1:0]  faultKind;
  logic        faultStage;
  logic [1:0]  faultLevel;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  xlat_size_guard uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .paSizeCode(paSizeCode),
    .faultMode(faultMode), .s1Enable(s1Enable), .s2Enable(s2Enable),
    .s1OutSizeCode(s1OutSizeCode), .s2OutSizeCode(s2OutSizeCode),
    .s1InSizeLo(s1InSizeLo), .s1InSizeHi(s1InSizeHi),
    .s1UpperRange(s1UpperRange), .s2InSize(s2InSize), .inAddr(inAddr),
    .s1TableBase(s1TableBase), .s1EntryAddr(s1EntryAddr),
    .s1EntryLevel(s1EntryLevel), .s1OutAddr(s1OutAddr),
    .s1OutLevel(s1OutLevel), .s2TableBase(s2TableBase),
    .s2EntryAddr(s2EntryAddr), .s2EntryLevel(s2EntryLevel),
    .s2OutAddr(s2OutAddr), .s2OutLevel(s2OutLevel), .rspValid(rspValid),
    .faultKind(faultKind), .faultStage(faultStage), .faultLevel(faultLevel)
  );

  task automatic apply(input vec_t v);
    logic [63:0] bad;
    bad           = 64'h1 << v.badBit;
    paSizeCode    = v.pa;
    faultMode     = v.mode;
    s1Enable      = v.s1En;
    s2Enable      = v.s2En;
    s1OutSizeCode = v.os1;
    s2OutSizeCode = v.os2;
    s1UpperRange  = v.hi;
    s1InSizeLo    = v.hi ? 6'd63 : v.t1;
    s1InSizeHi    = v.hi ? v.t1 : 6'd63;
    s2InSize      = v.t2;
    inAddr        = v.inA;
    s1TableBase   = 64'h1000 | ((v.badSel == 3'd1) ? bad : 64'h0);
    s1EntryAddr   = 64'h1000 | ((v.badSel == 3'd2) ? bad : 64'h0);
    s1OutAddr     = v.s1O;
    s2TableBase   = 64'h1000 | ((v.badSel == 3'd3) ? bad : 64'h0);
    s2EntryAddr   = 64'h1000 | ((v.badSel == 3'd4) ? bad : 64'h0);
    s2OutAddr     = v.s2O;
    s1EntryLevel  = 2'd2;
    s1OutLevel    = 2'd3;
    s2EntryLevel  = 2'd1;
    s2OutLevel    = 2'd3;
  endtask

  task automatic checkOut(input string what, input int req, input logic [5:0] expv);
    logic [5:0] got;
    got = {rspValid, faultKind, faultStage, faultLevel};
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL R%0d %s: actual=%b expected=%b (valid,kind,stage,level)",
               req, what, got, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : stim
    rstN     = 1'b0;
    reqValid = 1'b0;
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    checkOut("reset state", 10, 6'b000000); // R10
    rstN = 1'b1;
    @(negedge clk);
    checkOut("idle after reset", 10, 6'b000000); // R10

    // Back-to-back requests, one per cycle; result sampled one cycle later
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      reqValid = 1'b1;
      @(negedge clk);
      checkOut($sformatf("vector %0d", i), int'(VECS[i].req),
               {1'b1, VECS[i].eKind, VECS[i].eStg, VECS[i].eLvl});
    end

    // R10 idle cycle: valid drops, fields hold the last result
    reqValid = 1'b0;
    apply(VECS[0]);
    @(negedge clk);
    checkOut("idle hold", 10, {1'b0, VECS[NV-1].eKind, VECS[NV-1].eStg, VECS[NV-1].eLvl});

    // R11 stage 2 off while stage 2 input overflow present
    apply(VECS[21]);
    s2Enable = 1'b0;
    reqValid = 1'b1;
    @(negedge clk);
    checkOut("stage 2 off ignores ipa", 11, 6'b100000);

    // R10 asynchronous reset clears a fault result
    apply(VECS[1]);
    @(negedge clk);
    checkOut("fault before reset", 1, 6'b101011);
    reqValid = 1'b0;
    rstN     = 1'b0;
    #1;
    checkOut("reset clears", 10, 6'b000000);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("stays clear", 10, 6'b000000);

    summary();
    $finish;
  end

endmodule